// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block is a synchronous state machine that keeps track of which power mode a small processor system is in. There are six modes: normal run, stop, very-low-power run, very-low-power wait, very-low-power stop and very-low-leakage stop. On each clock it samples the software control fields, two protection enables, a sleep strobe with a deep-sleep qualifier, an interrupt and a wakeup-source event. From these it decides whether a legal transition is being asked for.

The controller reports the current mode and a submode code, both from registers. A move is accepted only when the protection enable and the field encoding both permit it. Any other sleep request leaves the mode where it is. The controller also records whether very-low-power stop was entered straight from normal run. In that case an interrupt returns the system to normal run and not to very-low-power run. Clock gating, regulator control and frequency limits are handled elsewhere.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. At the next clock edge it forces `mode` to RUN (0), clears `submode` to 0 and clears the direct-entry memory, whatever the other inputs are.
- R2: In RUN, a cycle with `sleep_req`=1, `deep_sleep`=1, `stop_sel`=000 and `run_sel`=00 moves the mode to STOP (1).
- R3: In STOP, `irq`=1 returns the mode to RUN. With `irq`=0 the mode stays STOP.
- R4: In RUN, when no sleep transition is taken, `allow_vlp`=1 together with `run_sel`=10 moves the mode to VLPR (2).
- R5: In VLPR, `run_sel`=00 moves the mode to RUN. This takes priority over any sleep request in the same cycle.
- R6: In VLPR, `sleep_req`=1 with `deep_sleep`=0 moves the mode to VLPW (3). In VLPW, `irq`=1 returns it to VLPR.
- R7: In VLPR, `sleep_req`=1 with `deep_sleep`=1 and `stop_sel` of 000 or 010 moves the mode to VLPS (4). An `irq` then returns it to VLPR.
- R8: In RUN, a deep-sleep request with `stop_sel`=010 and `allow_vlp`=1 moves the mode to VLPS and marks the entry as direct. An `irq` from such a VLPS returns the mode to RUN.
- R9: From RUN or VLPR, a deep-sleep request with `stop_sel`=100 and `allow_vll`=1 moves the mode to VLLS (5) and captures `leak_sel` into `submode`. Outside VLLS, `submode` reads 0.
- R10: In VLLS, only `wake_evt`=1 returns the mode to RUN. `irq` has no effect there, and `submode` holds its captured value.
- R11: A sleep request whose protection enable or field encoding does not permit any target leaves the current mode unchanged.
- R12: `mode` and `submode` are registered. They take their new value at the clock edge that samples the trigger, and keep their old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_sel | input | 2 | Run-mode control field (00 normal, 10 very-low-power) |
| stop_sel | input | 3 | Stop-mode control field (000 stop, 010 very-low-power stop, 100 very-low-leakage stop) |
| leak_sel | input | 2 | Leakage submode to capture on entry to VLLS |
| allow_vlp | input | 1 | Protection enable for very-low-power modes |
| allow_vll | input | 1 | Protection enable for very-low-leakage modes |
| sleep_req | input | 1 | Sleep request strobe |
| deep_sleep | input | 1 | Deep-sleep qualifier for the sleep request |
| irq | input | 1 | Interrupt |
| wake_evt | input | 1 | Enabled wakeup-source event |
| mode | output | 3 | Current mode: RUN 0, STOP 1, VLPR 2, VLPW 3, VLPS 4, VLLS 5 |
| submode | output | 2 | Captured leakage submode while in VLLS, else 0 |

## Verification
Two cases can fall in the same cycle. The first is a run-mode field change arriving together with a sleep request. In VLPR the field change must win. In RUN a legal sleep must win, and an illegal one must yield to the field change. The second is an interrupt arriving together with a wakeup event while in VLLS. The bench covers both by starting from each of seven reachable states, one of them the directly-entered VLPS, and then applying every combination of fields, enables, strobes, interrupt and wakeup in a single cycle. It judges the registered mode and submode one edge later against a bench model written from the requirements.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int RUN_W  = 2;
  localparam int STOP_W = 3;

  typedef enum logic [2:0] {
    PM_RUN  = 3'd0,
    PM_STOP = 3'd1,
    PM_VLPR = 3'd2,
    PM_VLPW = 3'd3,
    PM_VLPS = 3'd4,
    PM_VLLS = 3'd5
  } pm_mode_e;

  localparam logic [RUN_W-1:0]  RSEL_NORMAL = 2'b00;
  localparam logic [RUN_W-1:0]  RSEL_VLP    = 2'b10;
  localparam logic [STOP_W-1:0] SSEL_STOP   = 3'b000;
  localparam logic [STOP_W-1:0] SSEL_VLPS   = 3'b010;
  localparam logic [STOP_W-1:0] SSEL_VLLS   = 3'b100;
endpackage

// File: rtl/pwr_trans_decode.sv
module pwr_trans_decode
  import pwr_mode_pkg::*;
(
  input  pm_mode_e          cur_mode,
  input  logic              cur_direct,
  input  logic [RUN_W-1:0]  run_sel,
  input  logic [STOP_W-1:0] stop_sel,
  input  logic              allow_vlp,
  input  logic              allow_vll,
  input  logic              sleep_req,
  input  logic              deep_sleep,
  input  logic              irq,
  input  logic              wake_evt,
  output pm_mode_e          nxt_mode,
  output logic              nxt_direct,
  output logic              capture_sub
);
  logic deep_req, light_req;

  assign deep_req  = sleep_req & deep_sleep;
  assign light_req = sleep_req & ~deep_sleep;

  always_comb begin
    nxt_mode    = cur_mode;
    nxt_direct  = cur_direct;
    capture_sub = 1'b0;
    unique case (cur_mode)
      PM_RUN: begin
        nxt_direct = 1'b0;
        if (deep_req && stop_sel == SSEL_STOP && run_sel == RSEL_NORMAL) begin
          nxt_mode = PM_STOP;
        end else if (deep_req && stop_sel == SSEL_VLPS && allow_vlp) begin
          nxt_mode   = PM_VLPS;
          nxt_direct = 1'b1;
        end else if (deep_req && stop_sel == SSEL_VLLS && allow_vll) begin
          nxt_mode    = PM_VLLS;
          capture_sub = 1'b1;
        end else if (allow_vlp && run_sel == RSEL_VLP) begin
          nxt_mode = PM_VLPR;
        end
      end
      PM_STOP: begin
        if (irq) nxt_mode = PM_RUN;
      end
      PM_VLPR: begin
        if (run_sel == RSEL_NORMAL) begin
          nxt_mode = PM_RUN;
        end else if (light_req) begin
          nxt_mode = PM_VLPW;
        end else if (deep_req && (stop_sel == SSEL_STOP || stop_sel == SSEL_VLPS)) begin
          nxt_mode   = PM_VLPS;
          nxt_direct = 1'b0;
        end else if (deep_req && stop_sel == SSEL_VLLS && allow_vll) begin
          nxt_mode    = PM_VLLS;
          capture_sub = 1'b1;
        end
      end
      PM_VLPW: begin
        if (irq) nxt_mode = PM_VLPR;
      end
      PM_VLPS: begin
        if (irq) begin
          nxt_mode   = cur_direct ? PM_RUN : PM_VLPR;
          nxt_direct = 1'b0;
        end
      end
      PM_VLLS: begin
        if (wake_evt) nxt_mode = PM_RUN;
      end
      default: begin
        nxt_mode   = PM_RUN;
        nxt_direct = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
#(
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  pm_mode_e         nxt_mode,
  input  logic             nxt_direct,
  input  logic             capture_sub,
  input  logic [SUB_W-1:0] leak_sel,
  output pm_mode_e         mode_q,
  output logic             direct_q,
  output logic [SUB_W-1:0] sub_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_RUN;
      direct_q <= 1'b0;
      sub_q    <= '0;
    end else begin
      mode_q   <= nxt_mode;
      direct_q <= nxt_direct;
      if (capture_sub)
        sub_q <= leak_sel;
      else if (nxt_mode != PM_VLLS)
        sub_q <= '0;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SUB_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RUN_W-1:0]  run_sel,
  input  logic [STOP_W-1:0] stop_sel,
  input  logic [SUB_W-1:0]  leak_sel,
  input  logic              allow_vlp,
  input  logic              allow_vll,
  input  logic              sleep_req,
  input  logic              deep_sleep,
  input  logic              irq,
  input  logic              wake_evt,
  output logic [2:0]        mode,
  output logic [SUB_W-1:0]  submode
);
  pm_mode_e         cur_mode, nxt_mode;
  logic             cur_direct, nxt_direct, capture_sub;
  logic [SUB_W-1:0] sub_q;

  pwr_trans_decode u_dec (
    .cur_mode   (cur_mode),
    .cur_direct (cur_direct),
    .run_sel    (run_sel),
    .stop_sel   (stop_sel),
    .allow_vlp  (allow_vlp),
    .allow_vll  (allow_vll),
    .sleep_req  (sleep_req),
    .deep_sleep (deep_sleep),
    .irq        (irq),
    .wake_evt   (wake_evt),
    .nxt_mode   (nxt_mode),
    .nxt_direct (nxt_direct),
    .capture_sub(capture_sub)
  );

  pwr_mode_regs #(.SUB_W(SUB_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .nxt_mode   (nxt_mode),
    .nxt_direct (nxt_direct),
    .capture_sub(capture_sub),
    .leak_sel   (leak_sel),
    .mode_q     (cur_mode),
    .direct_q   (cur_direct),
    .sub_q      (sub_q)
  );

  assign mode    = cur_mode;
  assign submode = sub_q;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int SUB_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       run_sel,
  input logic [2:0]       stop_sel,
  input logic [SUB_W-1:0] leak_sel,
  input logic             allow_vlp,
  input logic             allow_vll,
  input logic             sleep_req,
  input logic             deep_sleep,
  input logic             irq,
  input logic             wake_evt,
  input logic [2:0]       mode,
  input logic [SUB_W-1:0] submode
);
  AST_RESET_TO_RUN: assert property (@(posedge clk)
    rst |=> (mode == 3'd0 && submode == '0)); // R1
  AST_STOP_IRQ_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd1 && irq) |=> mode == 3'd0); // R3
  AST_VLPR_FIELD_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && run_sel == 2'b00) |=> mode == 3'd0); // R5
  AST_VLPW_IRQ_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && irq) |=> mode == 3'd2); // R6
  AST_VLLS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && sleep_req && deep_sleep && stop_sel == 3'b100 && allow_vll)
      |=> (mode == 3'd5 && submode == $past(leak_sel))); // R9
  AST_SUB_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd5) |-> submode == '0); // R9
  AST_VLLS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd5 && !wake_evt) |=> (mode == 3'd5 && $stable(submode))); // R10
  AST_NO_VLP_UNPROTECTED: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && !allow_vlp) |=> (mode != 3'd2 && mode != 3'd4)); // R11
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd5); // R12
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst(rst), .run_sel(run_sel), .stop_sel(stop_sel),
  .leak_sel(leak_sel), .allow_vlp(allow_vlp), .allow_vll(allow_vll),
  .sleep_req(sleep_req), .deep_sleep(deep_sleep), .irq(irq),
  .wake_evt(wake_evt), .mode(mode), .submode(submode)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] run_sel = '0;
  logic [2:0] stop_sel = '0;
  logic [1:0] leak_sel = '0;
  logic       allow_vlp = 1'b0, allow_vll = 1'b0;
  logic       sleep_req = 1'b0, deep_sleep = 1'b0, irq = 1'b0, wake_evt = 1'b0;
  logic [2:0] mode;
  logic [1:0] submode;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .run_sel(run_sel), .stop_sel(stop_sel),
    .leak_sel(leak_sel), .allow_vlp(allow_vlp), .allow_vll(allow_vll),
    .sleep_req(sleep_req), .deep_sleep(deep_sleep), .irq(irq),
    .wake_evt(wake_evt), .mode(mode), .submode(submode)
  );

  // Expected next state from the requirements; returns {direct, sub, mode}
  function automatic logic [5:0] ref_next(logic [2:0] m, logic d, logic [1:0] sb,
      logic [1:0] r, logic [2:0] s, logic [1:0] l, logic av, logic al,
      logic sl, logic dp, logic iq, logic wk);
    logic [2:0] nm = m;
    logic nd = d;
    logic [1:0] ns = sb;
    case (m)
      3'd0: begin
        nd = 1'b0;
        if (sl && dp && s == 3'b000 && r == 2'b00) nm = 3'd1;
        else if (sl && dp && s == 3'b010 && av) begin nm = 3'd4; nd = 1'b1; end
        else if (sl && dp && s == 3'b100 && al) begin nm = 3'd5; ns = l; end
        else if (av && r == 2'b10) nm = 3'd2;
      end
      3'd1: if (iq) nm = 3'd0;
      3'd2: begin
        if (r == 2'b00) nm = 3'd0;
        else if (sl && !dp) nm = 3'd3;
        else if (sl && dp && (s == 3'b000 || s == 3'b010)) begin nm = 3'd4; nd = 1'b0; end
        else if (sl && dp && s == 3'b100 && al) begin nm = 3'd5; ns = l; end
      end
      3'd3: if (iq) nm = 3'd2;
      3'd4: if (iq) begin nm = d ? 3'd0 : 3'd2; nd = 1'b0; end
      3'd5: if (wk) nm = 3'd0;
      default: nm = 3'd0;
    endcase
    if (nm != 3'd5) ns = 2'd0;
    return {nd, ns, nm};
  endfunction

  function automatic string tag_of(int st, logic [2:0] em);
    case (st)
      0: return em == 3'd1 ? "R2" : em == 3'd2 ? "R4" : em == 3'd4 ? "R8" :
                em == 3'd5 ? "R9" : "R11";
      1: return "R3";
      2: return em == 3'd0 ? "R5" : em == 3'd3 ? "R6" : em == 3'd4 ? "R7" :
                em == 3'd5 ? "R9" : "R11";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic drv(logic [1:0] r, logic [2:0] s, logic [1:0] l, logic av,
      logic al, logic sl, logic dp, logic iq, logic wk);
    run_sel = r; stop_sel = s; leak_sel = l; allow_vlp = av; allow_vll = al;
    sleep_req = sl; deep_sleep = dp; irq = iq; wake_evt = wk;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [2:0] em, logic [1:0] es);
    n_chk++;
    if (mode !== em || submode !== es) begin
      n_fail++;
      $display("FAIL %s mode=%0d submode=%0d expected mode=%0d submode=%0d",
               req, mode, submode, em, es);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drv(2'b00, 3'b000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  // Bring the design to start state st; return expected {direct, sub, mode}
  task automatic reach(int st, output logic [5:0] ex);
    do_reset();
    case (st)
      0: ex = {1'b0, 2'd0, 3'd0};
      1: begin drv(2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); ex = {1'b0, 2'd0, 3'd1}; end
      2: begin drv(2'b10, 3'b000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); ex = {1'b0, 2'd0, 3'd2}; end
      3: begin
        drv(2'b10, 3'b000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drv(2'b10, 3'b000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ex = {1'b0, 2'd0, 3'd3};
      end
      4: begin
        drv(2'b10, 3'b000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drv(2'b10, 3'b000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        ex = {1'b0, 2'd0, 3'd4};
      end
      5: begin drv(2'b00, 3'b010, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); ex = {1'b1, 2'd0, 3'd4}; end
      default: begin drv(2'b00, 3'b100, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); ex = {1'b0, 2'd2, 3'd5}; end
    endcase
  endtask

  initial begin
    logic [5:0] st_ex, nx;
    @(negedge clk);
    do_reset();
    check("R1", 3'd0, 2'd0);

    // R12: the output keeps its value until the sampling edge
    run_sel = 2'b00; stop_sel = 3'b000; sleep_req = 1'b1; deep_sleep = 1'b1;
    #1;
    check("R12", 3'd0, 2'd0);
    @(negedge clk);
    check("R12", 3'd1, 2'd0);

    // R1: reset overrides a pending interrupt exit
    rst = 1'b1;
    drv(2'b10, 3'b000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    rst = 1'b0;
    check("R1", 3'd0, 2'd0);

    // R9: capture of leak code 3 from VLPR
    drv(2'b10, 3'b000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drv(2'b10, 3'b100, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9", 3'd5, 2'd3);
    // R10: interrupts held for several cycles have no effect in VLLS
    for (int k = 0; k < 4; k++) begin
      drv(2'b00, 3'b000, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      check("R10", 3'd5, 2'd3);
    end
    drv(2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10", 3'd0, 2'd0);

    // Sweep: every start state against every single-cycle input combination
    for (int st = 0; st < 7; st++) begin
      for (int v = 0; v < 4096; v++) begin
        logic [1:0] r  = v[1:0];
        logic [2:0] s  = v[4:2];
        logic [1:0] l  = v[5] ? 2'd1 : 2'd2;
        logic av = v[6], al = v[7], sl = v[8], dp = v[9], iq = v[10], wk = v[11];
        reach(st, st_ex);
        nx = ref_next(st_ex[2:0], st_ex[5], st_ex[4:3], r, s, l, av, al, sl, dp, iq, wk);
        drv(r, s, l, av, al, sl, dp, iq, wk);
        check(tag_of(st, nx[2:0]), nx[2:0], nx[4:3]);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog expired mode=%0d expected completion", mode);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule